// File: doc/BRIEF.md
# Corner Neighbour Reuse Controller for Adaptive Frame/Field Macroblock Pairs

The block supplies the upper-left corner neighbour pixel used for intra prediction when a picture is coded as a grid of vertical macroblock pairs. Each pair is coded in either frame or field mode. For every half of a pair (top macroblock, then bottom macroblock), the controller decides whether the first corner pixel can be **reused** from what it already holds or must be **reloaded** from the upper row data. It then presents that pixel one cycle before the first 4x4 block's prediction starts.

A reload takes its value from one of two candidate pixels of the pair above. Frame mode uses that pair's last row. Field mode uses its second-to-last row. Corner storage runs along the top of the picture, one entry per horizontal pair position, so the storage size is set by the picture width.

The block also keeps the left pair's mode. It captures the mode at the end of each pair and clears it to frame mode at the start of each pair row. The decision therefore needs only the current pair's mode, the left pair's mode and which half is being decoded.

Top module: `pair_corner_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `corner_valid`, `corner_reuse` and `corner_pix` are all 0.
- R2: For a top-half request (`half_start`=1, `is_bottom`=0), the registered decision is reuse (`corner_reuse`=1) exactly when `cur_field` equals the left pair's mode. Mode encoding: 0 = frame, 1 = field.
- R3: For a bottom-half request (`is_bottom`=1), the decision is reuse when `cur_field`=0 (frame pair) and reload when `cur_field`=1 (field pair).
- R4: On reload, `corner_pix` takes `cand_last` when `cur_field`=0 and `cand_prev` when `cur_field`=1. The reloaded value becomes the held corner.
- R5: On reuse, `corner_pix` equals the held corner. The held corner is, in priority order:
  - the value most recently reloaded in this pair;
  - otherwise, the storage entry read at the last `pair_done`;
  - otherwise, 0 after `row_start`.
- R6: The left pair's mode is captured from `cur_field` on `pair_done` and is cleared to frame (0) on `row_start`.
- R7: Storage holds one `PIX_W`-bit entry per column, `MB_COLS` entries. On `pair_done`, the entry at the current column is first read into the held corner, then overwritten with `upd_pix`. The column then advances, wrapping from `MB_COLS-1` to 0. `row_start` returns the column to 0, and storage contents survive `row_start`.
- R8: `corner_valid` is high for exactly the one cycle after a `half_start` cycle. While it is low, `corner_pix` and `corner_reuse` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_start | input | 1 | Pulse: a new row of pairs begins |
| pair_done | input | 1 | Pulse: the current pair is finished |
| half_start | input | 1 | Pulse: request the corner for the half named by `is_bottom` |
| is_bottom | input | 1 | 0 = top macroblock, 1 = bottom macroblock |
| cur_field | input | 1 | Current pair mode, 0 = frame, 1 = field |
| cand_last | input | PIX_W | Candidate from the last row of the pair above |
| cand_prev | input | PIX_W | Candidate from the second-to-last row of the pair above |
| upd_pix | input | PIX_W | Pixel written into storage at `pair_done` |
| corner_valid | output | 1 | One-cycle strobe: decision and pixel are fresh |
| corner_reuse | output | 1 | 1 = reuse, 0 = reload |
| corner_pix | output | PIX_W | Corner neighbour pixel |

## Verification
The assertions assume that the three control pulses (`row_start`, `pair_done`, `half_start`) never coincide. They also assume that `cur_field`, `is_bottom` and the candidate pixels are stable in the cycle of a `half_start` request. The bench drives each pulse alone for one cycle and sets the mode and candidates in the same cycle as the pulse. It sweeps several rows whose per-column modes are computed arithmetically, so every combination of current mode, left mode and half is reached. It also inserts a row restart in the middle of a row to exercise the return to frame mode and the storage that survives it.

// File: rtl/pair_corner_pkg.sv
package pair_corner_pkg;

  typedef enum logic {
    MODE_FRAME = 1'b0,
    MODE_FIELD = 1'b1
  } pair_mode_e;

  // Reuse/reload rule: top half follows mode agreement with the left pair,
  // bottom half follows the current pair mode alone.
  function automatic logic f_reuse(input logic cur_fld,
                                   input logic left_fld,
                                   input logic bottom);
    if (bottom) f_reuse = (cur_fld == MODE_FRAME);
    else        f_reuse = (cur_fld == left_fld);
  endfunction

  // Reload row: frame takes the last row above, field the row before it.
  function automatic logic [15:0] f_pick(input logic        cur_fld,
                                         input logic [15:0] last_row,
                                         input logic [15:0] prev_row);
    f_pick = (cur_fld == MODE_FIELD) ? prev_row : last_row;
  endfunction

endpackage

// File: rtl/pair_mode_track.sv
module pair_mode_track #(
  parameter int MB_COLS = 5,
  localparam int COL_W = (MB_COLS > 1) ? $clog2(MB_COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_start,
  input  logic             pair_done,
  input  logic             cur_field,
  output logic             left_field,
  output logic [COL_W-1:0] col
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(MB_COLS - 1);

  wire col_wrap = (col == LAST_COL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_field <= 1'b0;
      col        <= '0;
    end else if (row_start) begin
      left_field <= 1'b0;
      col        <= '0;
    end else if (pair_done) begin
      left_field <= cur_field;
      col        <= col_wrap ? '0 : col + 1'b1;
    end
  end

  a_r6_row_frame: assert property (@(posedge clk) disable iff (!rst_n)
    row_start |=> !left_field);
  a_r6_latch_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_done && !row_start) |=> (left_field == $past(cur_field)));
  a_r7_col_range: assert property (@(posedge clk) disable iff (!rst_n)
    col <= LAST_COL);
  a_r7_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_done && !row_start && col == LAST_COL) |=> (col == '0));

endmodule

// File: rtl/pair_corner_store.sv
module pair_corner_store #(
  parameter int PIX_W   = 8,
  parameter int MB_COLS = 5,
  localparam int COL_W = (MB_COLS > 1) ? $clog2(MB_COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_start,
  input  logic             pair_done,
  input  logic [COL_W-1:0] col,
  input  logic [PIX_W-1:0] upd_pix,
  input  logic             ld_en,
  input  logic [PIX_W-1:0] ld_pix,
  output logic [PIX_W-1:0] keep_pix
);

  logic [PIX_W-1:0] top_mem [MB_COLS];

  for (genvar g = 0; g < MB_COLS; g++) begin : g_entry
    wire wr_hit = pair_done && !row_start && (col == COL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)      top_mem[g] <= '0;
      else if (wr_hit) top_mem[g] <= upd_pix;
    end
  end

  wire [PIX_W-1:0] rd_pix = top_mem[col];

  always_ff @(posedge clk) begin
    if (!rst_n)         keep_pix <= '0;
    else if (row_start) keep_pix <= '0;
    else if (pair_done) keep_pix <= rd_pix;
    else if (ld_en)     keep_pix <= ld_pix;
  end

  a_r5_row_clear: assert property (@(posedge clk) disable iff (!rst_n)
    row_start |=> (keep_pix == '0));
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !row_start && !pair_done) |=> (keep_pix == $past(ld_pix)));

endmodule

// File: rtl/pair_corner_decide.sv
module pair_corner_decide
  import pair_corner_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_start,
  input  logic             is_bottom,
  input  logic             cur_field,
  input  logic             left_field,
  input  logic [PIX_W-1:0] cand_last,
  input  logic [PIX_W-1:0] cand_prev,
  input  logic [PIX_W-1:0] keep_pix,
  output logic             ld_en,
  output logic [PIX_W-1:0] ld_pix,
  output logic             valid_q,
  output logic             reuse_q,
  output logic [PIX_W-1:0] pix_q
);

  wire              want_reuse = f_reuse(cur_field, left_field, is_bottom);
  wire [15:0]       pick_wide  = f_pick(cur_field, 16'(cand_last), 16'(cand_prev));
  wire [PIX_W-1:0]  reload_pix = pick_wide[PIX_W-1:0];

  assign ld_en  = half_start && !want_reuse;
  assign ld_pix = reload_pix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      reuse_q <= 1'b0;
      pix_q   <= '0;
    end else begin
      valid_q <= half_start;
      if (half_start) begin
        reuse_q <= want_reuse;
        pix_q   <= want_reuse ? keep_pix : reload_pix;
      end
    end
  end

  a_r2_top_match: assert property (@(posedge clk) disable iff (!rst_n)
    (half_start && !is_bottom) |=> (reuse_q == ($past(cur_field) == $past(left_field))));
  a_r3_bottom_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (half_start && is_bottom) |=> (reuse_q == !$past(cur_field)));
  a_r4_frame_last: assert property (@(posedge clk) disable iff (!rst_n)
    (half_start && !cur_field && !want_reuse) |=> (pix_q == $past(cand_last)));
  a_r4_field_prev: assert property (@(posedge clk) disable iff (!rst_n)
    (half_start && cur_field && !want_reuse) |=> (pix_q == $past(cand_prev)));
  a_r8_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    half_start |=> valid_q);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !half_start |=> (!valid_q && $stable(pix_q) && $stable(reuse_q)));

endmodule

// File: rtl/pair_corner_ctrl.sv
module pair_corner_ctrl #(
  parameter int PIX_W   = 8,
  parameter int MB_COLS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_start,
  input  logic             pair_done,
  input  logic             half_start,
  input  logic             is_bottom,
  input  logic             cur_field,
  input  logic [PIX_W-1:0] cand_last,
  input  logic [PIX_W-1:0] cand_prev,
  input  logic [PIX_W-1:0] upd_pix,
  output logic             corner_valid,
  output logic             corner_reuse,
  output logic [PIX_W-1:0] corner_pix
);

  localparam int COL_W = (MB_COLS > 1) ? $clog2(MB_COLS) : 1;

  logic             left_field;
  logic [COL_W-1:0] col;
  logic             ld_en;
  logic [PIX_W-1:0] ld_pix;
  logic [PIX_W-1:0] keep_pix;

  pair_mode_track #(.MB_COLS(MB_COLS)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_start  (row_start),
    .pair_done  (pair_done),
    .cur_field  (cur_field),
    .left_field (left_field),
    .col        (col)
  );

  pair_corner_store #(.PIX_W(PIX_W), .MB_COLS(MB_COLS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_start (row_start),
    .pair_done (pair_done),
    .col       (col),
    .upd_pix   (upd_pix),
    .ld_en     (ld_en),
    .ld_pix    (ld_pix),
    .keep_pix  (keep_pix)
  );

  pair_corner_decide #(.PIX_W(PIX_W)) u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_start (half_start),
    .is_bottom  (is_bottom),
    .cur_field  (cur_field),
    .left_field (left_field),
    .cand_last  (cand_last),
    .cand_prev  (cand_prev),
    .keep_pix   (keep_pix),
    .ld_en      (ld_en),
    .ld_pix     (ld_pix),
    .valid_q    (corner_valid),
    .reuse_q    (corner_reuse),
    .pix_q      (corner_pix)
  );

  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({row_start, pair_done, half_start}));
  a_r1_reset_out: assert property (@(posedge clk)
    !rst_n |=> (!corner_valid && !corner_reuse && corner_pix == '0));

endmodule

// File: tb/sim_pair_corner_ctrl.sv
module sim_pair_corner_ctrl;

  localparam int PW = 8;
  localparam int NC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_start = 0, pair_done = 0, half_start = 0, is_bottom = 0, cur_field = 0;
  logic [PW-1:0] cand_last = '0, cand_prev = '0, upd_pix = '0;
  logic corner_valid, corner_reuse;
  logic [PW-1:0] corner_pix;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model state
  logic m_left;
  int   m_col;
  logic [PW-1:0] m_keep;
  logic [PW-1:0] m_store [NC];
  logic [PW-1:0] last_pix;
  logic          last_reuse;

  always #4 clk = ~clk;

  pair_corner_ctrl #(.PIX_W(PW), .MB_COLS(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .pair_done(pair_done),
    .half_start(half_start), .is_bottom(is_bottom), .cur_field(cur_field),
    .cand_last(cand_last), .cand_prev(cand_prev), .upd_pix(upd_pix),
    .corner_valid(corner_valid), .corner_reuse(corner_reuse), .corner_pix(corner_pix)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic new_row();
    @(negedge clk) row_start = 1;
    @(negedge clk) row_start = 0;
    m_left = 0; m_col = 0; m_keep = '0;
  endtask

  task automatic do_half(input logic bot, input logic fld,
                         input logic [PW-1:0] cl, input logic [PW-1:0] cp);
    logic e_reuse;
    logic [PW-1:0] e_pix;
    @(negedge clk);
    half_start = 1; is_bottom = bot; cur_field = fld; cand_last = cl; cand_prev = cp;
    @(negedge clk);
    half_start = 0;
    // R2 / R3 rule, computed independently
    e_reuse = bot ? (fld == 1'b0) : (fld == m_left);
    // R4 reload rows, R5 reuse of held corner
    e_pix = e_reuse ? m_keep : (fld ? cp : cl);
    if (!e_reuse) m_keep = e_pix;
    chk(corner_valid == 1'b1, "R8 strobe after request", int'(corner_valid), 1);
    chk(corner_reuse == e_reuse, bot ? "R3 bottom decision" : "R2 top decision",
        int'(corner_reuse), int'(e_reuse));
    chk(corner_pix == e_pix, e_reuse ? "R5 reused pixel" : "R4 reloaded pixel",
        int'(corner_pix), int'(e_pix));
    last_pix = e_pix; last_reuse = e_reuse;
  endtask

  task automatic do_done(input logic fld, input logic [PW-1:0] up);
    @(negedge clk);
    pair_done = 1; cur_field = fld; upd_pix = up;
    @(negedge clk);
    pair_done = 0;
    // R6 left mode capture, R7 storage read-then-write and column wrap
    m_keep = m_store[m_col];
    m_store[m_col] = up;
    m_left = fld;
    m_col = (m_col == NC - 1) ? 0 : m_col + 1;
    chk(corner_valid == 1'b0, "R8 strobe low without request", int'(corner_valid), 0);
    chk(corner_pix == last_pix && corner_reuse == last_reuse, "R8 outputs hold",
        int'(corner_pix), int'(last_pix));
  endtask

  task automatic run_pair(input int row, input int c);
    logic fld;
    logic [PW-1:0] b;
    fld = logic'(((row * 3 + c * c + (row >> 1) * c) % 3) == 1 ? 1 : ((row + c) >> 2) & 1);
    b = PW'(row * 37 + c * 11 + 5);
    do_half(1'b0, fld, b, b ^ 8'h5A);
    do_half(1'b1, fld, b + 8'd3, b ^ 8'hC3);
    do_done(fld, PW'(row * 19 + c * 23 + 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) m_store[i] = '0;
    m_left = 0; m_col = 0; m_keep = '0; last_pix = '0; last_reuse = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(corner_valid == 0 && corner_reuse == 0 && corner_pix == 0, "R1 reset outputs",
        int'(corner_pix), 0);
    rst_n = 1;
    @(negedge clk);
    chk(corner_valid == 0 && corner_reuse == 0 && corner_pix == 0, "R1 after release",
        int'(corner_pix), 0);

    // Explicit corner sequence at row start: left mode is frame (R6)
    new_row();
    do_half(1'b0, 1'b1, 8'h11, 8'h22);  // field vs frame -> reload second-to-last (R4)
    do_half(1'b1, 1'b1, 8'h33, 8'h44);  // field bottom -> reload (R3)
    do_done(1'b1, 8'h90);
    do_half(1'b0, 1'b1, 8'h55, 8'h66);  // same mode -> reuse stored 0 (R2, R5)
    do_half(1'b1, 1'b0, 8'h77, 8'h88);  // frame bottom -> reuse (R3)
    do_done(1'b0, 8'h91);
    do_half(1'b0, 1'b0, 8'hA1, 8'hB2);  // frame after frame -> reuse
    do_done(1'b0, 8'h92);

    // Mid-row restart: left mode returns to frame, column to 0 (R6, R7)
    new_row();
    do_half(1'b0, 1'b0, 8'h01, 8'h02);  // frame vs reset frame -> reuse of 0
    do_done(1'b0, 8'h93);               // stored 0x90 read into held corner
    do_half(1'b0, 1'b0, 8'h03, 8'h04);  // reuse -> 0x90 proves storage kept (R7)

    // Sweep rows with arithmetic mode patterns, full wraps (R2..R8)
    for (int r = 0; r < 8; r++) begin
      new_row();
      for (int c = 0; c < NC + 2; c++) run_pair(r, c);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule